// File: doc/BRIEF.md
# Ping-Pong Block Transfer Planner

This block plans an acquisition that lands in memory through a transfer engine writing into two alternating buffers. A start pulse captures the request: either a counted acquisition of a given number of scans, each a given number of bytes long, or a continuous acquisition with no end. The planner breaks the counted byte total into whole-buffer blocks followed by one shorter trailing block. For each block it emits a one-cycle arm pulse together with the buffer select, that buffer's base address and the byte count to load into the engine.

The engine answers each completed block with a one-cycle done pulse. The planner then switches to the other buffer and arms the next block, or it raises its finished flag once the request is used up. A small write-only register port holds the two buffer base addresses and the buffer size. The size is stored as a power-of-two exponent.

Top module: `pingpong_xfer_planner`

## Requirements
- R1: Register port writes with `cfg_sel` 0 set the buffer-0 base address, 1 the buffer-1 base address, and 2 the buffer size exponent (low 5 bits of `cfg_wdata`, size = 2^exponent bytes). After reset the bases are 0 and the exponent is 14, giving 16384-byte buffers that hold 8192 16-bit samples. A write takes effect for starts from the following cycle.
- R2: One cycle after a start, `blk_arm` pulses with `buf_sel`=0 and the buffer-0 base address. In counted mode the count is a full buffer when the total (scans times bytes per scan) is at least the buffer size, and otherwise the whole total.
- R3: For each done pulse while busy, `buf_sel` inverts in the following cycle, and any block armed then carries the base address of the newly selected buffer.
- R4: A counted run arms exactly floor(total / size) full-size blocks, followed by one block of (total mod size) bytes when that remainder is non-zero.
- R5: When the total is an exact multiple of the buffer size, the run finishes on the done of the last full block, and no zero-length block is ever armed.
- R6: On the done of the last block, `busy` drops and `finished` rises in the next cycle. No further block is armed, and later done pulses change nothing.
- R7: In continuous mode every block is full-size and the run never finishes by itself.
- R8: A done pulse while not busy is ignored: no arm, and busy and finished keep their values.
- R9: A start while busy restarts the plan from buffer 0 with fresh counts. A start and a done in the same cycle act as a start only.
- R10: A counted start whose total is zero arms nothing, and sets `finished` with `busy` low in the next cycle.
- R11: `blk_arm` is high for one cycle per planned block, only while busy.
- R12: After reset `busy`, `finished` and `blk_arm` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 base 0, 1 base 1, 2 size exponent |
| cfg_wdata | input | ADDR_W | Register write data |
| start | input | 1 | Begin a new acquisition plan |
| cont_mode | input | 1 | 1 = continuous, 0 = counted |
| scan_count | input | SCAN_W | Requested number of scans (counted mode) |
| scan_bytes | input | BPS_W | Bytes per scan |
| blk_done | input | 1 | Transfer engine finished the current block |
| buf_sel | output | 1 | Buffer of the armed block |
| buf_addr | output | ADDR_W | Base address of the armed block |
| buf_bytes | output | CNT_W | Byte count of the armed block |
| blk_arm | output | 1 | One-cycle pulse: load and run this block |
| busy | output | 1 | A plan is in progress |
| finished | output | 1 | The last counted block completed |

## Verification
The bench builds the planner with its default widths: 32-bit addresses, 16-bit scan counts and 6-bit bytes per scan, so totals reach 22 bits. One counted run uses the reset-time 16 KiB buffer to show the default size and a remainder after two full blocks. The bench then writes small exponents of 3 and 4, which makes buffers of 8 and 16 bytes. With those sizes, long alternation chains, exact multiples, lone remainders, zero totals, restarts and continuous runs each take only a few dozen cycles. A behavioural model of the block sequence is compared with every output on every clock.

// File: rtl/ppx_pkg.sv
package ppx_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_t;

  localparam logic [1:0] SEL_BASE0 = 2'd0;
  localparam logic [1:0] SEL_BASE1 = 2'd1;
  localparam logic [1:0] SEL_SIZE  = 2'd2;
endpackage

// File: rtl/ppx_cfg_regs.sv
module ppx_cfg_regs #(
  parameter int ADDR_W    = 32,
  parameter int LOG_W     = 5,
  parameter int RESET_LOG = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] base0,
  output logic [ADDR_W-1:0] base1,
  output logic [LOG_W-1:0]  size_log
);
  import ppx_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      base0    <= '0;
      base1    <= '0;
      size_log <= LOG_W'(RESET_LOG);
    end else if (we) begin
      case (sel)
        SEL_BASE0: base0    <= wdata;
        SEL_BASE1: base1    <= wdata;
        SEL_SIZE:  size_log <= wdata[LOG_W-1:0];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/ppx_split.sv
module ppx_split #(
  parameter int SCAN_W = 16,
  parameter int BPS_W  = 6,
  parameter int LOG_W  = 5,
  localparam int CNT_W = SCAN_W + BPS_W
) (
  input  logic [SCAN_W-1:0] scans,
  input  logic [BPS_W-1:0]  bps,
  input  logic [LOG_W-1:0]  size_log,
  output logic [CNT_W-1:0]  size,
  output logic [CNT_W-1:0]  full_runs,
  output logic [CNT_W-1:0]  remainder
);
  logic [CNT_W-1:0] total;

  always_comb begin
    total     = CNT_W'(scans) * CNT_W'(bps);
    size      = CNT_W'(1) << size_log;
    full_runs = total >> size_log;
    remainder = total & (size - CNT_W'(1));
  end
endmodule

// File: rtl/ppx_seq.sv
module ppx_seq #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cont_mode,
  input  logic              blk_done,
  input  logic [ADDR_W-1:0] base0,
  input  logic [ADDR_W-1:0] base1,
  input  logic [CNT_W-1:0]  size,
  input  logic [CNT_W-1:0]  full_runs,
  input  logic [CNT_W-1:0]  remainder,
  output logic              buf_sel,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [CNT_W-1:0]  buf_bytes,
  output logic              blk_arm,
  output logic              busy,
  output logic              finished,
  output logic              run_cont,
  output logic [CNT_W-1:0]  run_size
);
  import ppx_pkg::*;

  phase_t                   phase;
  logic signed [CNT_W:0]    runs_left;
  logic [CNT_W-1:0]         rem_q;

  assign busy = (phase == PH_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      finished  <= 1'b0;
      blk_arm   <= 1'b0;
      buf_sel   <= 1'b0;
      buf_addr  <= '0;
      buf_bytes <= '0;
      runs_left <= '0;
      rem_q     <= '0;
      run_cont  <= 1'b0;
      run_size  <= '0;
    end else begin
      blk_arm <= 1'b0;
      if (start) begin
        finished  <= 1'b0;
        buf_sel   <= 1'b0;
        buf_addr  <= base0;
        run_cont  <= cont_mode;
        run_size  <= size;
        rem_q     <= remainder;
        runs_left <= $signed({1'b0, full_runs}) - 1;
        if (cont_mode || full_runs != '0) begin
          phase     <= PH_RUN;
          blk_arm   <= 1'b1;
          buf_bytes <= size;
        end else if (remainder != '0) begin
          phase     <= PH_RUN;
          blk_arm   <= 1'b1;
          buf_bytes <= remainder;
        end else begin
          phase    <= PH_IDLE;
          finished <= 1'b1;
        end
      end else if (phase == PH_RUN && blk_done) begin
        buf_sel  <= ~buf_sel;
        buf_addr <= buf_sel ? base0 : base1;
        if (run_cont) begin
          blk_arm   <= 1'b1;
          buf_bytes <= run_size;
        end else begin
          runs_left <= runs_left - 1;
          if (runs_left > 0) begin
            blk_arm   <= 1'b1;
            buf_bytes <= run_size;
          end else if (runs_left == 0 && rem_q != '0) begin
            blk_arm   <= 1'b1;
            buf_bytes <= rem_q;
          end else begin
            phase    <= PH_IDLE;
            finished <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pingpong_xfer_planner.sv
module pingpong_xfer_planner #(
  parameter int ADDR_W    = 32,
  parameter int SCAN_W    = 16,
  parameter int BPS_W     = 6,
  parameter int RESET_LOG = 14,
  localparam int CNT_W    = SCAN_W + BPS_W,
  localparam int LOG_W    = $clog2(CNT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              start,
  input  logic              cont_mode,
  input  logic [SCAN_W-1:0] scan_count,
  input  logic [BPS_W-1:0]  scan_bytes,
  input  logic              blk_done,
  output logic              buf_sel,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [CNT_W-1:0]  buf_bytes,
  output logic              blk_arm,
  output logic              busy,
  output logic              finished
);
  logic [ADDR_W-1:0] base0, base1;
  logic [LOG_W-1:0]  size_log;
  logic [CNT_W-1:0]  size, full_runs, remainder;
  logic              run_cont;
  logic [CNT_W-1:0]  run_size;

  ppx_cfg_regs #(.ADDR_W(ADDR_W), .LOG_W(LOG_W), .RESET_LOG(RESET_LOG)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .base0(base0), .base1(base1), .size_log(size_log)
  );

  ppx_split #(.SCAN_W(SCAN_W), .BPS_W(BPS_W), .LOG_W(LOG_W)) u_split (
    .scans(scan_count), .bps(scan_bytes), .size_log(size_log),
    .size(size), .full_runs(full_runs), .remainder(remainder)
  );

  ppx_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .cont_mode(cont_mode), .blk_done(blk_done),
    .base0(base0), .base1(base1), .size(size), .full_runs(full_runs),
    .remainder(remainder), .buf_sel(buf_sel), .buf_addr(buf_addr),
    .buf_bytes(buf_bytes), .blk_arm(blk_arm), .busy(busy), .finished(finished),
    .run_cont(run_cont), .run_size(run_size)
  );
endmodule

// File: rtl/ppx_checker.sv
module ppx_checker #(
  parameter int CNT_W = 22
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             blk_done,
  input logic             buf_sel,
  input logic [CNT_W-1:0] buf_bytes,
  input logic             blk_arm,
  input logic             busy,
  input logic             finished,
  input logic             run_cont,
  input logic [CNT_W-1:0] run_size
);
  assert_arm_while_busy_R11: assert property (@(posedge clk) disable iff (rst)
    blk_arm |-> busy);

  assert_finished_idle_R6: assert property (@(posedge clk) disable iff (rst)
    finished |-> !busy);

  assert_start_buf0_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> (!buf_sel && (blk_arm || finished)));

  assert_done_toggles_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && blk_done && !start) |=> (buf_sel != $past(buf_sel)));

  assert_idle_done_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && blk_done && !start) |=> (!blk_arm && !busy && $stable(finished)));

  assert_no_zero_block_R5: assert property (@(posedge clk) disable iff (rst)
    blk_arm |-> (buf_bytes != '0));

  assert_cont_full_R7: assert property (@(posedge clk) disable iff (rst)
    (blk_arm && run_cont) |-> (buf_bytes == run_size));

  assert_cont_never_ends_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && run_cont && !start) |=> busy);
endmodule

bind pingpong_xfer_planner ppx_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .blk_done(blk_done), .buf_sel(buf_sel),
  .buf_bytes(buf_bytes), .blk_arm(blk_arm), .busy(busy), .finished(finished),
  .run_cont(run_cont), .run_size(run_size)
);

// File: tb/pingpong_xfer_planner_tb.sv
module pingpong_xfer_planner_tb;
  localparam int ADDR_W = 32;
  localparam int SCAN_W = 16;
  localparam int BPS_W  = 6;
  localparam int CNT_W  = SCAN_W + BPS_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [ADDR_W-1:0] cfg_wdata = '0;
  logic start = 1'b0, cont_mode = 1'b0, blk_done = 1'b0;
  logic [SCAN_W-1:0] scan_count = '0;
  logic [BPS_W-1:0] scan_bytes = '0;
  logic buf_sel, blk_arm, busy, finished;
  logic [ADDR_W-1:0] buf_addr;
  logic [CNT_W-1:0] buf_bytes;

  pingpong_xfer_planner u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .start(start), .cont_mode(cont_mode), .scan_count(scan_count),
    .scan_bytes(scan_bytes), .blk_done(blk_done), .buf_sel(buf_sel),
    .buf_addr(buf_addr), .buf_bytes(buf_bytes), .blk_arm(blk_arm),
    .busy(busy), .finished(finished)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string cur_tag = "R12";

  // behavioural model state
  bit m_arm = 0, m_busy = 0, m_fin = 0, m_sel = 0, m_cont = 0;
  logic [31:0] m_b0 = 0, m_b1 = 0, m_addr = 0;
  int m_log = 14, m_bytes = 0, m_rem = 0, m_sz = 0, m_left = 0;
  int total = 0, sz = 0, nf = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_arm = 0; m_busy = 0; m_fin = 0; m_sel = 0;
      m_b0 = 0; m_b1 = 0; m_log = 14;
    end else begin
      m_arm = 0;
      if (start) begin
        total  = int'(scan_count) * int'(scan_bytes);
        sz     = 1 << m_log;
        nf     = total / sz;
        m_rem  = total % sz;
        m_sz   = sz;
        m_cont = cont_mode;
        m_sel  = 0;
        m_addr = m_b0;
        m_fin  = 0;
        if (cont_mode) begin
          m_arm = 1; m_busy = 1; m_bytes = sz;
        end else if (nf > 0) begin
          m_arm = 1; m_busy = 1; m_bytes = sz; m_left = nf - 1;
        end else if (m_rem > 0) begin
          m_arm = 1; m_busy = 1; m_bytes = m_rem; m_left = -1;
        end else begin
          m_busy = 0; m_fin = 1;
        end
      end else if (blk_done && m_busy) begin
        m_sel  = !m_sel;
        m_addr = m_sel ? m_b1 : m_b0;
        if (m_cont) begin
          m_arm = 1; m_bytes = m_sz;
        end else if (m_left > 0) begin
          m_arm = 1; m_bytes = m_sz; m_left--;
        end else if (m_left == 0 && m_rem > 0) begin
          m_arm = 1; m_bytes = m_rem; m_left = -1;
        end else begin
          m_busy = 0; m_fin = 1;
        end
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_b0 = cfg_wdata;
          2'd1: m_b1 = cfg_wdata;
          2'd2: m_log = int'(cfg_wdata[4:0]);
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", cur_tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cycles++;
      check(blk_arm == m_arm, "R11 blk_arm", blk_arm, m_arm);
      check(busy == m_busy, "busy", busy, m_busy);
      check(finished == m_fin, "R6 finished", finished, m_fin);
      if (m_arm) begin
        check(buf_sel == m_sel, "R3 buf_sel", buf_sel, m_sel);
        check(buf_addr == m_addr, "R1 buf_addr", buf_addr, m_addr);
        check(int'(buf_bytes) == m_bytes, "R4 buf_bytes", buf_bytes, m_bytes);
      end
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic go(input bit c, input int sc, input int bp);
    @(negedge clk);
    start = 1; cont_mode = c; scan_count = SCAN_W'(sc); scan_bytes = BPS_W'(bp);
    @(negedge clk); start = 0;
  endtask

  task automatic done_pulse(input int gap);
    repeat (gap) @(negedge clk);
    blk_done = 1;
    @(negedge clk); blk_done = 0;
  endtask

  task automatic drain(input int max_blocks);
    for (int i = 0; i < max_blocks; i++) begin
      if (!busy) break;
      done_pulse(2);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_tag = "R12";
    check(!busy && !finished && !blk_arm, "R12 reset outputs", {busy, finished, blk_arm}, 0);

    cur_tag = "R1";            // default 16 KiB buffer: 40000 = 2 x 16384 + 7232
    go(0, 1000, 40);
    check(int'(buf_bytes) == 16384, "R1 default size", buf_bytes, 16384);
    drain(6);

    wr(2'd0, 32'h0000_1000);
    wr(2'd1, 32'h0000_8000);
    wr(2'd2, 32'd4);           // 16-byte buffers

    cur_tag = "R2";            // 5 bytes fits inside one buffer
    go(0, 1, 5);
    drain(4);

    cur_tag = "R4";            // 35 bytes: 16, 16, 3
    go(0, 5, 7);
    drain(6);

    cur_tag = "R3";            // 200 bytes: 12 full + 8
    go(0, 20, 10);
    drain(20);

    cur_tag = "R5";            // exact multiple: 32 bytes
    go(0, 4, 8);
    drain(6);

    cur_tag = "R6";            // done after finish is ignored
    done_pulse(1);
    repeat (2) @(negedge clk);
    check(finished && !busy, "R6 stays finished", finished, 1);

    cur_tag = "R8";            // idle done after reset-like idle
    done_pulse(0);
    done_pulse(0);
    repeat (2) @(negedge clk);

    cur_tag = "R7";            // continuous
    go(1, 1, 1);
    for (int i = 0; i < 7; i++) done_pulse(1);
    check(busy && !finished, "R7 still running", busy, 1);

    cur_tag = "R9";            // restart while busy, start with done together
    @(negedge clk);
    start = 1; blk_done = 1; cont_mode = 0; scan_count = 3; scan_bytes = 11;
    @(negedge clk); start = 0; blk_done = 0;
    drain(6);

    cur_tag = "R9";            // restart mid counted run, smaller size
    wr(2'd2, 32'd3);
    go(0, 9, 9);
    done_pulse(1);
    done_pulse(1);
    go(0, 2, 13);
    drain(8);

    cur_tag = "R10";           // zero total
    go(0, 0, 12);
    repeat (2) @(negedge clk);
    check(finished && !busy, "R10 zero total", finished, 1);
    go(0, 7, 0);
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule